// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the protocol side of a serial memory that sits on a two-wire bus. A fast system clock oversamples the bus clock and data lines. The block finds bus start and stop conditions and shifts in a device-select byte, which it compares against three strap inputs. It then accepts a two-byte word address and data bytes, or it shifts read data out. Each byte it accepts is acknowledged by pulling the data line low during the ninth bus clock. The block does not hold memory. It issues one-cycle byte requests to a neighbouring address counter and page buffer: load an address, accept a write byte, commit a write, or supply the next read byte.

The supported transactions are byte write, page write, current-address read, random read and sequential read. A random read is a write header carrying the address, followed by a repeated start and a read header. While the neighbour reports that an internal write cycle is running, the block refuses the device-select byte. A host can therefore poll for completion.

The request outputs form a one-directional stream with no back-pressure, because the bus clock is never stretched. Each request is a single-cycle valid pulse, and the neighbour must take it in that cycle. For a read request, `rd_data` must already hold the requested byte during the cycle in which `rd_req` is high. The neighbour advances its pointer at the end of that cycle.

Top module: `ee2w_slave`

## Requirements
- R1: After reset the block does not drive the data line (`sda_oe` = 0). A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high.
- R2: The first byte after a start is received MSB first. Its bits 7..4 must be 1010, bits 3..1 must equal `strap[2:0]`, and bit 0 selects read (1) or write (0). On a match the block acknowledges by holding the data line low through the ninth clock.
- R3: On a device-select mismatch the block gives no acknowledge, issues no request and ignores all bytes until the next start.
- R4: While `wr_busy` is high the device-select byte is not acknowledged. Once `wr_busy` is low, the same byte is acknowledged.
- R5: In a write transaction, two acknowledged address bytes follow the device byte. The top 3 bits of the first byte are ignored. After the second byte, `addr_load` pulses once with the 13-bit address {first[4:0], second}.
- R6: Every data byte after the address is acknowledged and presented as a one-cycle `wr_valid` pulse carrying the byte on `wr_data`.
- R7: A stop after at least one data byte pulses `wr_commit` once. A stop with no data byte, including a stop during the address bytes, gives no commit.
- R8: After an acknowledged read header, `rd_req` pulses once. The byte on `rd_data` is then driven MSB first, with each bit changing after a clock fall.
- R9: A master acknowledge after a read byte issues another `rd_req` and sends the next byte. A missing acknowledge releases the line, and no further request is made until a start.
- R10: A random read (write header, two address bytes, repeated start, read header) gives `addr_load` then `rd_req`, and never a commit.
- R11: A start inside a byte aborts it, and the following bits are taken as a new device-select byte.
- R12: `sda_oe` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Device-select strap value |
| wr_busy | input | 1 | Neighbour's internal write cycle is running |
| rd_data | input | 8 | Byte at the neighbour's pointer, valid while `rd_req` is high |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| addr_load | output | 1 | One-cycle pulse: load `addr_value` into the address counter |
| addr_value | output | 13 | Word address to load |
| wr_valid | output | 1 | One-cycle pulse: write byte for the page buffer |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse: start the internal write cycle |
| rd_req | output | 1 | One-cycle pulse: take `rd_data`, then advance the pointer |

## Verification
The assertions check four properties on every cycle. The data-line enable moves only while the filtered clock is low. At most one request pulse is active at a time. Write bytes and read requests follow a clock rise, and a commit follows a stop. A start always puts the controller back into device-select reception with the line released.

The bench scenarios cover the rest. These are the values of acknowledge bits, the exact request sequence for each transaction type, and address handling: the ignored top bits and read wrap from the last address to zero. They also cover silence after a mismatch or while busy, and the absence of a commit after aborted or read-only transactions.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADRH,
    ST_ADRL,
    ST_WR,
    ST_RD,
    ST_WAIT
  } ee2w_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/ee2w_filter.sv
module ee2w_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             win_q;
  logic                   vote;

  assign vote = (win_q[0] & win_q[1]) | (win_q[1] & win_q[2]) | (win_q[0] & win_q[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      win_q  <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
      dout   <= vote;
    end
  end
endmodule

// File: rtl/ee2w_cond.sv
module ee2w_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/ee2w_fsm.sv
module ee2w_fsm
  import ee2w_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int STRAP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic              wr_busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              addr_load,
  output logic [ADDR_W-1:0] addr_value,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit,
  output logic              rd_req
);
  localparam int HI_W = ADDR_W - BYTE_W;

  ee2w_state_e       state, nxt;
  logic [3:0]        cnt;
  logic              in_ack;
  logic              m_ack;
  logic              got_data;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic [HI_W-1:0]   hi_q;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {rx_q[BYTE_W-2:0], sda_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      nxt        <= ST_IDLE;
      cnt        <= '0;
      in_ack     <= 1'b0;
      m_ack      <= 1'b0;
      got_data   <= 1'b0;
      rx_q       <= '0;
      tx_q       <= '1;
      hi_q       <= '0;
      sda_oe     <= 1'b0;
      addr_load  <= 1'b0;
      addr_value <= '0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      wr_commit  <= 1'b0;
      rd_req     <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      rd_req    <= 1'b0;
      if (rd_req) tx_q <= rd_data;

      if (start_det) begin
        state    <= ST_DEV;
        cnt      <= '0;
        in_ack   <= 1'b0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else if (stop_det) begin
        if (state == ST_WR && got_data) wr_commit <= 1'b1;
        state  <= ST_IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE && state != ST_WAIT) begin
        if (scl_rise) begin
          if (!in_ack) begin
            cnt <= cnt + 4'd1;
            if (state != ST_RD) begin
              rx_q <= byte_in;
              if (cnt == 4'd7) begin
                case (state)
                  ST_DEV: begin
                    if (byte_in[7:4] == DEV_CODE && byte_in[3:1] == strap && !wr_busy) begin
                      nxt <= byte_in[0] ? ST_RD : ST_ADRH;
                      if (byte_in[0]) rd_req <= 1'b1;
                    end else begin
                      state <= ST_WAIT;
                      cnt   <= '0;
                    end
                  end
                  ST_ADRH: begin
                    hi_q <= byte_in[HI_W-1:0];
                    nxt  <= ST_ADRL;
                  end
                  ST_ADRL: begin
                    addr_load  <= 1'b1;
                    addr_value <= {hi_q, byte_in};
                    nxt        <= ST_WR;
                  end
                  default: begin
                    wr_valid <= 1'b1;
                    wr_data  <= byte_in;
                    got_data <= 1'b1;
                    nxt      <= ST_WR;
                  end
                endcase
              end
            end
          end else if (state == ST_RD) begin
            m_ack <= ~sda_lvl;
            if (!sda_lvl) rd_req <= 1'b1;
          end
        end else if (scl_fall) begin
          if (!in_ack && cnt == 4'd8) begin
            in_ack <= 1'b1;
            sda_oe <= (state != ST_RD);
          end else if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= '0;
            if (state == ST_RD && !m_ack) begin
              state  <= ST_WAIT;
              sda_oe <= 1'b0;
            end else begin
              if (state != ST_RD) state <= nxt;
              if (state == ST_RD || nxt == ST_RD) begin
                sda_oe <= ~tx_q[BYTE_W-1];
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b1};
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end else if (state == ST_RD && cnt != 4'd0) begin
            sda_oe <= ~tx_q[BYTE_W-1];
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b1};
          end
        end
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl); // R12
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_load, wr_valid, wr_commit, rd_req})); // R5
  AST_WR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(scl_rise)); // R6
  AST_COMMIT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_det)); // R7
  AST_RDREQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $past(scl_rise)); // R9
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV && !sda_oe && cnt == 4'd0)); // R11
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave #(
  parameter int ADDR_W      = 13,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_busy,
  input  logic [7:0]         rd_data,
  output logic               sda_oe,
  output logic               addr_load,
  output logic [ADDR_W-1:0]  addr_value,
  output logic               wr_valid,
  output logic [7:0]         wr_data,
  output logic               wr_commit,
  output logic               rd_req
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_w, flt_w;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    ee2w_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_w[g]),
      .dout (flt_w[g])
    );
  end

  ee2w_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (flt_w[0]),
    .sda_f    (flt_w[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  ee2w_fsm #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (flt_w[0]),
    .sda_lvl   (flt_w[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap),
    .wr_busy   (wr_busy),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .addr_load (addr_load),
    .addr_value(addr_value),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_commit (wr_commit),
    .rd_req    (rd_req)
  );
endmodule

// File: tb/ee2w_slave_bench.sv
module ee2w_slave_bench;
  localparam int CLK_P = 10;
  localparam int Q     = 20;
  localparam logic [2:0] K_AL = 3'd1, K_WR = 3'd2, K_CM = 3'd3, K_RD = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wr_busy = 1'b0;
  logic [7:0] rd_data;
  logic sda_oe, addr_load, wr_valid, wr_commit, rd_req;
  logic [12:0] addr_value;
  logic [7:0] wr_data;
  logic sda_line;
  logic [12:0] ptr;
  logic [15:0] exp_q[$];
  int total = 0, bad = 0, oe_bad = 0;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  assign rd_data = pat(ptr);

  ee2w_slave u_ee2w_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap(strap),
    .wr_busy(wr_busy), .rd_data(rd_data), .sda_oe(sda_oe), .addr_load(addr_load),
    .addr_value(addr_value), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_commit(wr_commit), .rd_req(rd_req)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (addr_load) ptr <= addr_value;
    else if (wr_valid) ptr[4:0] <= ptr[4:0] + 5'd1;
    else if (rd_req) ptr <= ptr + 13'd1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] got;
      logic hit;
      hit = 1'b1;
      if (addr_load) got = {K_AL, addr_value};
      else if (wr_valid) got = {K_WR, 5'd0, wr_data};
      else if (wr_commit) got = {K_CM, 13'd0};
      else if (rd_req) got = {K_RD, 13'd0};
      else hit = 1'b0;
      if (hit) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 R7 R10 unexpected request", int'(got), 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R5 R6 R7 R8 request", int'(got), int'(e));
        end
      end
      if (sda_oe != prev_oe && m_scl) oe_bad++;
      prev_oe = sda_oe;
    end
  end

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(); m_scl = 1'b1; tick(); m_sda = 1'b0; tick(); m_scl = 1'b0; tick();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(); m_scl = 1'b1; tick(); m_sda = 1'b1; tick(); tick();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(); m_scl = 1'b1; tick(); tick(); m_scl = 1'b0; tick();
  endtask

  task automatic read_bit(output logic b);
    m_sda = 1'b1; tick(); m_scl = 1'b1; tick(); b = sda_line; tick(); m_scl = 1'b0; tick();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) read_bit(v[i]);
    send_bit(~give_ack);
  endtask

  task automatic push(input logic [2:0] k, input logic [12:0] v);
    exp_q.push_back({k, v});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 idle after reset", int'(sda_oe), 0);

    // R2 R5 R6 R7 byte write, top bits of first address byte ignored
    push(K_AL, 13'h0345); push(K_WR, 13'h005A); push(K_CM, 13'h0);
    bus_start();
    send_byte(8'hAA, a); chk(a, "R1 R2 header ack", a, 1);
    send_byte(8'hE3, a); chk(a, "R5 addr hi ack", a, 1);
    send_byte(8'h45, a); chk(a, "R5 addr lo ack", a, 1);
    send_byte(8'h5A, a); chk(a, "R6 data ack", a, 1);
    bus_stop();

    // R6 R7 page write of three bytes
    push(K_AL, 13'h0FFE); push(K_WR, 13'h00A1); push(K_WR, 13'h00B2); push(K_WR, 13'h00C3);
    push(K_CM, 13'h0);
    bus_start();
    send_byte(8'hAA, a); send_byte(8'h0F, a); send_byte(8'hFE, a);
    send_byte(8'hA1, a); chk(a, "R6 page byte 0 ack", a, 1);
    send_byte(8'hB2, a); chk(a, "R6 page byte 1 ack", a, 1);
    send_byte(8'hC3, a); chk(a, "R6 page byte 2 ack", a, 1);
    bus_stop();

    // R3 strap mismatch, then silence
    bus_start();
    send_byte(8'hA6, a); chk(!a, "R3 strap mismatch nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R3 ignored after mismatch", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hBA, a); chk(!a, "R2 bad code nack", a, 0);
    bus_stop();

    // R4 busy refuses device byte
    wr_busy = 1'b1;
    bus_start();
    send_byte(8'hAA, a); chk(!a, "R4 busy nack", a, 0);
    bus_stop();
    wr_busy = 1'b0;
    bus_start();
    send_byte(8'hAA, a); chk(a, "R4 ack after busy clears", a, 1);
    bus_stop();

    // R10 R8 R9 random read with wrap from last address to zero
    push(K_AL, 13'h1FFF); push(K_RD, 13'h0); push(K_RD, 13'h0); push(K_RD, 13'h0);
    bus_start();
    send_byte(8'hAA, a); send_byte(8'hFF, a); send_byte(8'hFF, a);
    bus_start();
    send_byte(8'hAB, a); chk(a, "R10 read header ack", a, 1);
    recv_byte(1'b1, d); chk(d == pat(13'h1FFF), "R8 first read byte", d, pat(13'h1FFF));
    recv_byte(1'b1, d); chk(d == pat(13'h0000), "R9 sequential wrap", d, pat(13'h0000));
    recv_byte(1'b0, d); chk(d == pat(13'h0001), "R9 last byte", d, pat(13'h0001));
    bus_stop();

    // R8 current-address read
    push(K_RD, 13'h0);
    bus_start();
    send_byte(8'hAB, a); chk(a, "R8 current read ack", a, 1);
    recv_byte(1'b0, d); chk(d == pat(13'h0002), "R8 current read byte", d, pat(13'h0002));
    bus_stop();

    // R11 start in the middle of a byte
    push(K_AL, 13'h0010); push(K_WR, 13'h0077); push(K_CM, 13'h0);
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'hAA, a); chk(a, "R11 header after abort", a, 1);
    send_byte(8'h00, a); send_byte(8'h10, a);
    send_byte(8'h77, a); chk(a, "R11 data after abort", a, 1);
    bus_stop();

    // R7 stop during address bytes, and stop right after address
    bus_start();
    send_byte(8'hAA, a); send_byte(8'h01, a); chk(a, "R5 hi ack before stop", a, 1);
    bus_stop();
    push(K_AL, 13'h0102);
    bus_start();
    send_byte(8'hAA, a); send_byte(8'h01, a); send_byte(8'h02, a);
    bus_stop();

    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R7 R10 all expected requests seen", exp_q.size(), 0);
    chk(oe_bad == 0, "R12 sda_oe stable while clock high", oe_bad, 0);
    finish_run();
  end
endmodule